// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line carries a tag, a data word and a two-bit coherence state (Invalid, Shared, Exclusive or Modified). The processor side hands in one load or store at a time. The block answers hits from its own line store. On a miss or an upgrade it requests the bus and issues one of three commands. A read fetches a block. A read-with-invalidate fetches a block and clears every other copy. An invalidate clears other copies without a fetch.

At the same time the block watches commands that other caches put on the bus. When one of them touches a line it holds, it reports a shared copy, supplies the data if its own copy is dirty, and demotes or drops the line. A dirty victim is written back through its own write stream before the refill is requested.

The processor request is a valid/ready handshake. `cpu_req_ready` is high only while the controller is idle. A request is taken on a clock edge where both valid and ready are high, and the requester keeps its fields stable until then. The response is a single-cycle `cpu_rsp_valid` pulse that cannot be stalled. The write-back stream is valid/ready: `wb_valid` and its address and data stay fixed until an edge where `wb_ready` is high. The bus and the snoop pins are plain control signals.

A block address has `ADDR_W` bits. The low `log2(SETS)` bits pick the line and the rest form the tag. Bus command codes are 00 idle, 01 read, 10 read-with-invalidate and 11 invalidate.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1 and `bus_req`, `wb_valid` and `cpu_rsp_valid` are 0. The first load of any address therefore issues a read command.
- R2: A load that hits a valid line with a matching tag returns the line data with `cpu_rsp_valid` on the second clock edge after acceptance. It raises no `bus_req`.
- R3: A load miss issues a read (01) for the block address and returns `fill_data`. The line is installed Exclusive if `fill_shared` was 0 with the fill, and Shared if it was 1.
- R4: A read (01) snooped from another requester ID that hits a valid line drives `snp_shared` high in the same cycle. If the line is Modified it also drives `snp_supply` high, with the line data on `snp_data`. The line becomes Shared.
- R5: A read-with-invalidate (10) snooped from another ID that hits a valid line drives the same shared and supply signals as R4. The line becomes Invalid.
- R6: An invalidate (11) snooped from another ID that hits a valid line makes it Invalid and leaves `snp_shared` and `snp_supply` low.
- R7: Snooped commands that carry this block's own `NODE_ID` leave `snp_shared` and `snp_supply` low and change no line.
- R8: A store that hits a Shared line issues an invalidate (11) and, once granted, responds without a fill. The line is then Modified and holds the store data.
- R9: A store that hits an Exclusive or Modified line raises no `bus_req`, responds on the second edge after acceptance, and leaves the line Modified with the store data.
- R10: A store miss issues a read-with-invalidate (10). After the fill the line is Modified and holds the store data, and `fill_data` is discarded.
- R11: A miss whose victim line is Modified first presents the victim tag and index with its data on the write-back stream, held until `wb_ready`. No `bus_req` is raised before that. A clean victim is dropped without write-back.
- R12: If a pending upgrade store loses its Shared line to a snooped command before its grant, the command it issues becomes read-with-invalidate (10).
- R13: `bus_req` stays high with a stable `bus_addr` until `bus_gnt`. `bus_cmd` is 00 whenever `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 store, 0 load |
| cpu_req_addr | input | ADDR_W | Block address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data (store data for stores) |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant; command is issued in a cycle with bus_req and bus_gnt high |
| bus_cmd | output | 2 | Issued command code |
| bus_addr | output | ADDR_W | Block address of the command |
| bus_id | output | ID_W | This block's requester ID |
| fill_valid | input | 1 | Refill data for the outstanding read is present |
| fill_shared | input | 1 | Some other cache reported a copy |
| fill_data | input | DATA_W | Refill data |
| wb_valid | output | 1 | Victim write-back valid |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | ADDR_W | Victim block address |
| wb_data | output | DATA_W | Victim data |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_id | input | ID_W | Requester ID of the snooped command |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The bench walks one line through every state and probes it from the bus side after each step. A dirty line that failed to supply, or a supplied word that was not the last store, shows up as wrong `snp_supply` or `snp_data`. The command chosen by the next store reveals whether a fill landed in Exclusive or Shared: a design that ignored `fill_shared` would skip the invalidate or issue a needless one. A dirty-victim store miss checks that the write-back carries the old tag and data and comes before the request. A design that fetched first would lose the dirty word. The upgrade race, with an invalidate snooped while the store waits for its grant, catches a controller that latched its command early and would then write a line it no longer holds.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
`timescale 1ns/1ps
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  // local port: read and priority write
  input  logic [IDX_W-1:0]  a_idx,
  output mesi_e             a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              a_we,
  input  mesi_e             a_state_in,
  input  logic              a_tag_we,
  input  logic [TAG_W-1:0]  a_tag_in,
  input  logic              a_data_we,
  input  logic [DATA_W-1:0] a_data_in,
  // snoop port: read and state-only write
  input  logic [IDX_W-1:0]  b_idx,
  output mesi_e             b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              b_we,
  input  mesi_e             b_state_in
);
  mesi_e             st_v  [SETS];
  logic [TAG_W-1:0]  tag_v [SETS];
  logic [DATA_W-1:0] dat_v [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_line
    mesi_e             st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              sel_a, sel_b;

    assign sel_a = a_we && (a_idx == IDX_W'(s));
    assign sel_b = b_we && (b_idx == IDX_W'(s));

    // local writes win over a snoop update of the same line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_I;
        tag_r <= '0;
      end else if (sel_a) begin
        st_r <= a_state_in;
        if (a_tag_we) tag_r <= a_tag_in;
      end else if (sel_b) begin
        st_r <= b_state_in;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_a && a_data_we) dat_r <= a_data_in;
    end

    assign st_v[s]  = st_r;
    assign tag_v[s] = tag_r;
    assign dat_v[s] = dat_r;
  end

  assign a_state = st_v[a_idx];
  assign a_tag   = tag_v[a_idx];
  assign a_data  = dat_v[a_idx];
  assign b_state = st_v[b_idx];
  assign b_tag   = tag_v[b_idx];
  assign b_data  = dat_v[b_idx];
endmodule

// File: rtl/mesi_snoop.sv
`timescale 1ns/1ps
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 2,
  parameter int DATA_W = 32,
  parameter logic [ID_W-1:0] OWN_ID = '0,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_cmd_e          cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   id,
  output logic [IDX_W-1:0]  line_idx,
  input  mesi_e             line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd_en,
  output mesi_e             upd_state,
  output logic              shared,
  output logic              supply,
  output logic [DATA_W-1:0] sup_data
);
  logic foreign, hit;

  assign line_idx = addr[IDX_W-1:0];
  assign foreign  = (cmd != CMD_IDLE) && (id != OWN_ID);
  assign hit      = foreign && (line_state != ST_I) && (line_tag == addr[ADDR_W-1:IDX_W]);

  always_comb begin
    shared    = 1'b0;
    supply    = 1'b0;
    upd_en    = 1'b0;
    upd_state = line_state;
    if (hit) begin
      unique case (cmd)
        CMD_RD: begin
          shared    = 1'b1;
          supply    = (line_state == ST_M);
          upd_en    = 1'b1;
          upd_state = ST_S;
        end
        CMD_RDX: begin
          shared    = 1'b1;
          supply    = (line_state == ST_M);
          upd_en    = 1'b1;
          upd_state = ST_I;
        end
        CMD_INV: begin
          upd_en    = 1'b1;
          upd_state = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign sup_data = supply ? line_data : '0;

  // R7: commands tagged with this cache's own ID stay silent
  a_r7_own_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_IDLE && id == OWN_ID) |-> (!shared && !supply && !upd_en));

  // R4 / R5: dirty data is only ever supplied together with the shared flag
  a_r4_supply_with_shared: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> shared);

  // R6: an invalidate never reports a copy
  a_r6_inv_not_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INV) |-> !shared);
endmodule

// File: rtl/mesi_req_fsm.sv
`timescale 1ns/1ps
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  // line store, local port
  output logic [IDX_W-1:0]  la_idx,
  input  mesi_e             la_state,
  input  logic [TAG_W-1:0]  la_tag,
  input  logic [DATA_W-1:0] la_data,
  output logic              wa_en,
  output mesi_e             wa_state,
  output logic              wa_tag_en,
  output logic [TAG_W-1:0]  wa_tag,
  output logic              wa_data_en,
  output logic [DATA_W-1:0] wa_data,
  // snoop activity this cycle
  input  logic              snp_upd_en,
  input  logic [IDX_W-1:0]  snp_idx,
  // bus master side
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              fill_valid,
  input  logic              fill_shared,
  input  logic [DATA_W-1:0] fill_data,
  // victim write-back stream
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  typedef enum logic [2:0] {F_IDLE, F_CHECK, F_WB, F_ARB, F_FILL} seq_e;

  seq_e              st_q, st_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_fire;
  logic [DATA_W-1:0] rsp_data;
  logic [TAG_W-1:0]  req_tag;
  logic              hit, clash;
  bus_cmd_e          arb_cmd;

  assign la_idx  = addr_q[IDX_W-1:0];
  assign req_tag = addr_q[ADDR_W-1:IDX_W];
  assign hit     = (la_state != ST_I) && (la_tag == req_tag);
  assign clash   = snp_upd_en && (snp_idx == la_idx);

  // the command is chosen from the line as it stands at grant time
  always_comb begin
    if (!wr_q)                      arb_cmd = CMD_RD;
    else if (hit && la_state == ST_S) arb_cmd = CMD_INV;
    else                            arb_cmd = CMD_RDX;
  end

  assign cpu_req_ready = (st_q == F_IDLE);
  assign bus_cmd       = bus_req ? arb_cmd : CMD_IDLE;
  assign bus_addr      = addr_q;
  assign wb_addr       = {la_tag, la_idx};
  assign wb_data       = la_data;
  assign wa_tag        = req_tag;

  always_comb begin
    st_d       = st_q;
    wa_en      = 1'b0;
    wa_state   = ST_I;
    wa_tag_en  = 1'b0;
    wa_data_en = 1'b0;
    wa_data    = wdata_q;
    rsp_fire   = 1'b0;
    rsp_data   = la_data;
    bus_req    = 1'b0;
    wb_valid   = 1'b0;
    unique case (st_q)
      F_IDLE: if (cpu_req_valid) st_d = F_CHECK;
      F_CHECK: begin
        if (!clash) begin
          if (hit && !wr_q) begin
            rsp_fire = 1'b1;
            st_d     = F_IDLE;
          end else if (hit && la_state != ST_S) begin
            wa_en      = 1'b1;
            wa_state   = ST_M;
            wa_data_en = 1'b1;
            rsp_fire   = 1'b1;
            rsp_data   = wdata_q;
            st_d       = F_IDLE;
          end else if (hit) begin
            st_d = F_ARB;
          end else if (la_state == ST_M) begin
            st_d = F_WB;
          end else begin
            wa_en    = (la_state != ST_I);
            wa_state = ST_I;
            st_d     = F_ARB;
          end
        end
      end
      F_WB: begin
        wb_valid = 1'b1;
        if (wb_ready) begin
          wa_en    = 1'b1;
          wa_state = ST_I;
          st_d     = F_ARB;
        end
      end
      F_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          if (arb_cmd == CMD_INV) begin
            wa_en      = 1'b1;
            wa_state   = ST_M;
            wa_data_en = 1'b1;
            rsp_fire   = 1'b1;
            rsp_data   = wdata_q;
            st_d       = F_IDLE;
          end else begin
            st_d = F_FILL;
          end
        end
      end
      F_FILL: begin
        if (fill_valid) begin
          wa_en      = 1'b1;
          wa_tag_en  = 1'b1;
          wa_data_en = 1'b1;
          if (wr_q) begin
            wa_state = ST_M;
            wa_data  = wdata_q;
          end else begin
            wa_state = fill_shared ? ST_S : ST_E;
            wa_data  = fill_data;
          end
          rsp_fire = 1'b1;
          rsp_data = wa_data;
          st_d     = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= F_IDLE;
      wr_q          <= 1'b0;
      addr_q        <= '0;
      wdata_q       <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      st_q          <= st_d;
      cpu_rsp_valid <= rsp_fire;
      if (rsp_fire) cpu_rsp_rdata <= rsp_data;
      if (cpu_req_valid && cpu_req_ready) begin
        wr_q    <= cpu_req_write;
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  // R11: no bus request while a victim is being written back
  a_r11_wb_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !bus_req);

  // R11: write-back held stable until accepted
  a_r11_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R13: request held with the same address until granted
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

  // R2: no response in the cycle right after acceptance
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_rsp_valid);
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SETS    = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 2,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ID_W-1:0]   bus_id,
  input  logic              fill_valid,
  input  logic              fill_shared,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(NODE_ID);

  logic [IDX_W-1:0]  la_idx, sb_idx;
  mesi_e             la_state, sb_state, wa_state, sb_upd_state;
  logic [TAG_W-1:0]  la_tag, sb_tag, wa_tag;
  logic [DATA_W-1:0] la_data, sb_data, wa_data;
  logic              wa_en, wa_tag_en, wa_data_en, sb_upd_en;
  bus_cmd_e          fsm_cmd;

  assign bus_id  = OWN_ID;
  assign bus_cmd = fsm_cmd;

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(la_idx), .a_state(la_state), .a_tag(la_tag), .a_data(la_data),
    .a_we(wa_en), .a_state_in(wa_state), .a_tag_we(wa_tag_en), .a_tag_in(wa_tag),
    .a_data_we(wa_data_en), .a_data_in(wa_data),
    .b_idx(sb_idx), .b_state(sb_state), .b_tag(sb_tag), .b_data(sb_data),
    .b_we(sb_upd_en), .b_state_in(sb_upd_state)
  );

  mesi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .DATA_W(DATA_W),
               .OWN_ID(OWN_ID)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .cmd(bus_cmd_e'(snp_cmd)), .addr(snp_addr), .id(snp_id),
    .line_idx(sb_idx), .line_state(sb_state), .line_tag(sb_tag), .line_data(sb_data),
    .upd_en(sb_upd_en), .upd_state(sb_upd_state),
    .shared(snp_shared), .supply(snp_supply), .sup_data(snp_data)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .la_idx(la_idx), .la_state(la_state), .la_tag(la_tag), .la_data(la_data),
    .wa_en(wa_en), .wa_state(wa_state), .wa_tag_en(wa_tag_en), .wa_tag(wa_tag),
    .wa_data_en(wa_data_en), .wa_data(wa_data),
    .snp_upd_en(sb_upd_en), .snp_idx(sb_idx),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(fsm_cmd), .bus_addr(bus_addr),
    .fill_valid(fill_valid), .fill_shared(fill_shared), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // R13: idle code whenever the bus is not requested
  a_r13_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == 2'b00));
endmodule

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_req, bus_gnt = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [IW-1:0] bus_id;
  logic          fill_valid = 1'b0, fill_shared = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic          wb_valid, wb_ready = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [1:0]    snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic [IW-1:0] snp_id = '0;
  logic          snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  mesi_line_ctrl #(.ADDR_W(AW), .SETS(4), .DATA_W(DW), .ID_W(IW), .NODE_ID(0)) i_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_id(bus_id), .fill_valid(fill_valid), .fill_shared(fill_shared),
    .fill_data(fill_data), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_id(snp_id), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_data(snp_data)
  );

  always #2 clk = ~clk;

  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_INV = 2'b11;
  localparam logic [IW-1:0] OTHER = 2'd1, SELF = 2'd0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // observations of the last access
  logic [1:0]    o_cmd;
  logic [AW-1:0] o_addr;
  bit            o_wb, o_wb_first;
  logic [AW-1:0] o_wb_addr;
  logic [DW-1:0] o_wb_data, o_rdata;
  int            o_lat;
  // observations of the last snoop
  logic          s_sh, s_su;
  logic [DW-1:0] s_d;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one processor access, with the bench acting as bus, arbiter and memory
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] fd, input bit fsh);
    bit fill_pend = 1'b0;
    bit done = 1'b0;
    o_cmd = C_NONE; o_addr = '0; o_wb = 1'b0; o_wb_first = 1'b0;
    o_wb_addr = '0; o_wb_data = '0; o_rdata = 'x; o_lat = -1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int i = 0; i < 60 && !done; i++) begin
      bus_gnt = 1'b0; wb_ready = 1'b0; fill_valid = 1'b0;
      if (cpu_rsp_valid) begin
        o_rdata = cpu_rsp_rdata; o_lat = i; done = 1'b1;
      end else if (fill_pend) begin
        fill_valid = 1'b1; fill_data = fd; fill_shared = fsh; fill_pend = 1'b0;
      end else if (wb_valid) begin
        o_wb = 1'b1; o_wb_addr = wb_addr; o_wb_data = wb_data; wb_ready = 1'b1;
      end else if (bus_req) begin
        o_cmd = bus_cmd; o_addr = bus_addr; o_wb_first = o_wb; bus_gnt = 1'b1;
        fill_pend = (bus_cmd == C_RD) || (bus_cmd == C_RDX);
      end
      if (!done) @(negedge clk);
    end
    bus_gnt = 1'b0; wb_ready = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [IW-1:0] id);
    @(negedge clk);
    snp_cmd = c; snp_addr = a; snp_id = id;
    #1;
    s_sh = snp_shared; s_su = snp_supply; s_d = snp_data;
    @(negedge clk);
    snp_cmd = C_NONE;
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", 32'(cpu_req_ready), 32'd1);
    chk("R1 no bus_req after reset", 32'(bus_req), 32'd0);
    chk("R1 no wb_valid after reset", 32'(wb_valid), 32'd0);
    chk("R1 no rsp after reset", 32'(cpu_rsp_valid), 32'd0);
    chk("R13 idle cmd after reset", 32'(bus_cmd), 32'(C_NONE));
  endtask

  // line at index 0 through I -> E -> M -> S -> M -> I
  task automatic t_exclusive_path();
    access(1'b0, 8'h10, '0, 32'hA000_0001, 1'b0);
    chk("R1 first load issues read", 32'(o_cmd), 32'(C_RD));
    chk("R3 read address", 32'(o_addr), 32'h10);
    chk("R3 load miss data", o_rdata, 32'hA000_0001);
    access(1'b0, 8'h10, '0, '0, 1'b0);
    chk("R2 hit no bus cmd", 32'(o_cmd), 32'(C_NONE));
    chk("R2 hit latency", 32'(o_lat), 32'd1);
    chk("R2 hit data", o_rdata, 32'hA000_0001);
    access(1'b1, 8'h10, 32'h1111_0001, '0, 1'b0);
    chk("R3 excl install store silent", 32'(o_cmd), 32'(C_NONE));
    chk("R9 store hit latency", 32'(o_lat), 32'd1);
    snoop(C_RD, 8'h10, OTHER);
    chk("R4 shared on read snoop", 32'(s_sh), 32'd1);
    chk("R4 supply when modified", 32'(s_su), 32'd1);
    chk("R9 supplied store data", s_d, 32'h1111_0001);
    access(1'b0, 8'h10, '0, '0, 1'b0);
    chk("R2 hit in shared data", o_rdata, 32'h1111_0001);
    chk("R2 hit in shared silent", 32'(o_cmd), 32'(C_NONE));
    access(1'b1, 8'h10, 32'h2222_0002, '0, 1'b0);
    chk("R4 line demoted so store invalidates", 32'(o_cmd), 32'(C_INV));
    chk("R8 invalidate address", 32'(o_addr), 32'h10);
    chk("R8 response without fill", 32'(o_lat), 32'd2);
    snoop(C_RDX, 8'h10, OTHER);
    chk("R5 shared on rdx snoop", 32'(s_sh), 32'd1);
    chk("R5 supply on rdx snoop", 32'(s_su), 32'd1);
    chk("R8 line modified with store data", s_d, 32'h2222_0002);
    access(1'b0, 8'h10, '0, 32'hA000_0003, 1'b1);
    chk("R5 line invalid after rdx snoop", 32'(o_cmd), 32'(C_RD));
    snoop(C_RD, 8'h10, OTHER);
    chk("R4 shared copy no supply", 32'(s_su), 32'd0);
    chk("R4 shared copy reports shared", 32'(s_sh), 32'd1);
  endtask

  task automatic t_shared_install();
    access(1'b0, 8'h21, '0, 32'hB000_0000, 1'b1);
    chk("R3 read on miss idx1", 32'(o_cmd), 32'(C_RD));
    chk("R3 fill data idx1", o_rdata, 32'hB000_0000);
    access(1'b1, 8'h21, 32'h3333_0003, '0, 1'b0);
    chk("R3 shared install needs invalidate", 32'(o_cmd), 32'(C_INV));
  endtask

  task automatic t_snoop_inv();
    access(1'b0, 8'h22, '0, 32'hC000_0000, 1'b0);
    snoop(C_INV, 8'h22, OTHER);
    chk("R6 invalidate not shared", 32'(s_sh), 32'd0);
    chk("R6 invalidate no supply", 32'(s_su), 32'd0);
    access(1'b0, 8'h22, '0, 32'hC000_0001, 1'b0);
    chk("R6 line invalid after snoop", 32'(o_cmd), 32'(C_RD));
    chk("R6 refetched data", o_rdata, 32'hC000_0001);
  endtask

  task automatic t_own_id();
    access(1'b0, 8'h23, '0, 32'hD000_0000, 1'b0);
    access(1'b1, 8'h23, 32'h4444_0004, '0, 1'b0);
    chk("R9 store hit exclusive silent", 32'(o_cmd), 32'(C_NONE));
    snoop(C_RDX, 8'h23, SELF);
    chk("R7 own id no shared", 32'(s_sh), 32'd0);
    chk("R7 own id no supply", 32'(s_su), 32'd0);
    snoop(C_INV, 8'h23, SELF);
    snoop(C_RD, 8'h23, OTHER);
    chk("R7 line kept modified", 32'(s_su), 32'd1);
    chk("R7 line data kept", s_d, 32'h4444_0004);
  endtask

  task automatic t_store_miss_dirty();
    access(1'b1, 8'h05, 32'h5555_0005, 32'hEEEE_0000, 1'b0);
    chk("R11 dirty victim written back", 32'(o_wb), 32'd1);
    chk("R11 victim address", 32'(o_wb_addr), 32'h21);
    chk("R11 victim data", o_wb_data, 32'h3333_0003);
    chk("R11 write-back before request", 32'(o_wb_first), 32'd1);
    chk("R10 store miss command", 32'(o_cmd), 32'(C_RDX));
    chk("R10 store miss address", 32'(o_addr), 32'h05);
    snoop(C_RD, 8'h05, OTHER);
    chk("R10 line modified after fill", 32'(s_su), 32'd1);
    chk("R10 store data kept over fill", s_d, 32'h5555_0005);
  endtask

  task automatic t_store_miss_clean();
    access(1'b1, 8'h0A, 32'h6666_0006, 32'hEEEE_0001, 1'b0);
    chk("R11 clean victim no write-back", 32'(o_wb), 32'd0);
    chk("R10 clean store miss command", 32'(o_cmd), 32'(C_RDX));
  endtask

  // store waits on a shared line, then loses it before the grant
  task automatic t_upgrade_race();
    bit got = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h23;
    cpu_req_wdata = 32'h7777_0007;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    @(negedge clk);
    chk("R8 upgrade requests bus", 32'(bus_req), 32'd1);
    chk("R12 first command invalidate", 32'(bus_cmd), 32'(C_INV));
    snp_cmd = C_INV; snp_addr = 8'h23; snp_id = OTHER;
    @(negedge clk);
    snp_cmd = C_NONE;
    chk("R13 request held without grant", 32'(bus_req), 32'd1);
    chk("R13 address held", 32'(bus_addr), 32'h23);
    chk("R12 command becomes rdx", 32'(bus_cmd), 32'(C_RDX));
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; fill_valid = 1'b1; fill_data = 32'hEEEE_0002; fill_shared = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0;
    got = cpu_rsp_valid;
    chk("R12 response after refill", 32'(got), 32'd1);
    snoop(C_RD, 8'h23, OTHER);
    chk("R12 line modified with store data", s_d, 32'h7777_0007);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_install();
    t_snoop_inv();
    t_own_id();
    t_store_miss_dirty();
    t_store_miss_clean();
    t_upgrade_race();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule